// File: doc/BRIEF.md
# Linked Full-Bridge Center-Aligned PWM

This block drives the four switches of a full-bridge converter primary: two legs, each with a high-side and a low-side gate. Both legs run from one triangular time base that counts up to the period and back down to zero. The active high-side pulse of leg 1 sits symmetrically around the top of the count. Each leg turns its raw pulse into a complementary pair separated by a programmable dead time. Leg 2 runs 180 degrees from leg 1 because its high and low outputs are swapped. It has no phase offset counter.

Period, duty and dead time are taken from the inputs into shadow copies only at the counter-zero instant, or continuously while the block is disabled. The period in force is broadcast on a link output, so that further time bases (for instance secondary-side legs) follow one period setting. No periodic sync is produced. A single-cycle resync pulse marks each zero instant at which a new period or duty value comes into force.

Top module: `fbpwm_bridge`

## Requirements
- R1: While enabled, the counter steps 0,1,…,P,P-1,…,1 and repeats, so one switching cycle lasts 2·P clocks, where P is the period in force. The counter never exceeds P.
- R2: The leg 1 raw pulse is high while the counter is at least P+1−D, where D is the duty in force. This gives a raw pulse 2·D−1 clocks wide, centered on the count value P. The leg 1 high output is high for 2·D−1−T clocks per cycle, where T is the dead time in clocks.
- R3: At each raw edge, both outputs of a leg stay low for T clocks, so the leg 1 low output is high for 2·P−2·D+1−T clocks per cycle. The high and low outputs of a leg are never high together. T=0 gives purely complementary outputs.
- R4: Leg 2 high equals leg 1 low, and leg 2 low equals leg 1 high, on every clock.
- R5: The duty in force is min(duty input, P−T), floored at 0. A duty of 0 keeps every high-side-of-leg-1 output low and leaves leg 1 low continuously on.
- R6: A period input below 2 is taken as 2.
- R7: Period, duty and dead time inputs take effect only at a counter-zero instant. The link output shows the period in force and holds between zero instants.
- R8: The resync output pulses for exactly one clock at a zero instant where the loaded period or duty differs from the values in force. It does not pulse periodically, for a dead-time-only change, or while disabled.
- R9: When enable is low, all four gate outputs are low from the next clock and the counter is held at zero. While disabled, the inputs load every clock, so the link output follows the period input one clock later.
- R10: In reset, all gate outputs and the resync output are low and the link output reads 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low forces all gates off |
| prd_i | input | CW | Period in clocks (top of count) |
| duty_i | input | CW | Duty: raw pulse half-width in clocks |
| dt_i | input | DTW | Dead time in clocks |
| leg1_hi_o | output | 1 | Leg 1 high-side gate |
| leg1_lo_o | output | 1 | Leg 1 low-side gate |
| leg2_hi_o | output | 1 | Leg 2 high-side gate |
| leg2_lo_o | output | 1 | Leg 2 low-side gate |
| prd_link_o | output | CW | Period in force, for linked time bases |
| resync_o | output | 1 | One-clock pulse when a new period or duty comes into force |

## Verification
The bench measures complete switching cycles for several period, duty and dead-time sets. This exposes an off-by-one in the top turnaround as a cycle length other than 2·P, and misplaced dead time as wrong high or low widths. Clamping is tested by asking for a duty far beyond P−T, a zero duty and a period of 1. A missing clamp would overlap the legs or stretch the high pulse. A missing floor would fold the counter over. A period change written near the top of the count must leave the link output unchanged until zero. Without that, a half-applied update would show up at once. The resync pulse is counted over long windows and across a dead-time-only change. A free-running sync, or one that fires on any input change, would add pulses.

// File: rtl/fbpwm_pkg.sv
package fbpwm_pkg;

    localparam int CW_DEF   = 16;
    localparam int DTW_DEF  = 8;
    localparam int MINP_DEF = 2;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } cnt_dir_e;

endpackage

// File: rtl/fbpwm_timebase.sv
module fbpwm_timebase
    import fbpwm_pkg::*;
#(
    parameter int CW = CW_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] prd_act,
    output logic [CW-1:0] cnt,
    output logic          load
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        cnt_dir_e      dir;
    } tb_state_t;

    tb_state_t tb_d, tb_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        tb_d    = tb_q;
        cnt_inc = tb_q.cnt + CW'(1);
        if (!en) begin
            tb_d.cnt = '0;
            tb_d.dir = DIR_UP;
        end else begin
            unique case (tb_q.dir)
                DIR_UP: begin
                    if (cnt_inc >= prd_act) begin
                        // reached the top: turn around on the next step
                        tb_d.cnt = prd_act;
                        tb_d.dir = DIR_DN;
                    end else begin
                        tb_d.cnt = cnt_inc;
                    end
                end
                DIR_DN: begin
                    if (tb_q.cnt <= CW'(1)) begin
                        tb_d.cnt = '0;
                        tb_d.dir = DIR_UP;
                    end else begin
                        tb_d.cnt = tb_q.cnt - CW'(1);
                    end
                end
                default: tb_d = tb_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q.cnt <= '0;
            tb_q.dir <= DIR_UP;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign cnt  = tb_q.cnt;
    assign load = !en || (tb_q.cnt == '0);

endmodule

// File: rtl/fbpwm_shadow.sv
module fbpwm_shadow
    import fbpwm_pkg::*;
#(
    parameter int CW   = CW_DEF,
    parameter int DTW  = DTW_DEF,
    parameter int MINP = MINP_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           load,
    input  logic [CW-1:0]  prd_in,
    input  logic [CW-1:0]  duty_in,
    input  logic [DTW-1:0] dt_in,
    output logic [CW-1:0]  prd_act,
    output logic [CW:0]    thr_act,
    output logic [DTW-1:0] dt_act,
    output logic           changed
);

    typedef struct packed {
        logic [CW-1:0]  prd;
        logic [CW-1:0]  duty;
        logic [CW:0]    thr;
        logic [DTW-1:0] dt;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic [CW-1:0] prd_new;
    logic [CW-1:0] dt_ext;
    logic [CW-1:0] duty_lim;
    logic [CW-1:0] duty_new;
    logic [CW:0]   thr_new;

    always_comb begin
        // period floor
        prd_new  = (prd_in < CW'(MINP)) ? CW'(MINP) : prd_in;
        // duty ceiling leaves room for one dead time inside the period
        dt_ext   = CW'(dt_in);
        duty_lim = (prd_new > dt_ext) ? (prd_new - dt_ext) : '0;
        duty_new = (duty_in > duty_lim) ? duty_lim : duty_in;
        // raw pulse starts where the counter reaches this threshold
        thr_new  = {1'b0, prd_new} + (CW+1)'(1) - {1'b0, duty_new};

        sh_d = sh_q;
        if (load) begin
            sh_d.prd  = prd_new;
            sh_d.duty = duty_new;
            sh_d.thr  = thr_new;
            sh_d.dt   = dt_in;
        end
        changed = en && load && ((prd_new != sh_q.prd) || (duty_new != sh_q.duty));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.prd  <= CW'(MINP);
            sh_q.duty <= '0;
            sh_q.thr  <= (CW+1)'(MINP + 1);
            sh_q.dt   <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign prd_act = sh_q.prd;
    assign thr_act = sh_q.thr;
    assign dt_act  = sh_q.dt;

endmodule

// File: rtl/fbpwm_resync.sv
module fbpwm_resync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic changed,
    output logic pulse
);

    typedef struct packed {
        logic pulse;
    } rs_state_t;

    rs_state_t rs_d, rs_q;

    always_comb begin
        rs_d       = rs_q;
        rs_d.pulse = en && changed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q.pulse <= 1'b0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign pulse = rs_q.pulse;

endmodule

// File: rtl/fbpwm_leg.sv
module fbpwm_leg
    import fbpwm_pkg::*;
#(
    parameter int CW   = CW_DEF,
    parameter int DTW  = DTW_DEF,
    parameter bit SWAP = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [CW-1:0]  cnt,
    input  logic [CW:0]    thr,
    input  logic [DTW-1:0] dt,
    output logic           gate_hi,
    output logic           gate_lo
);

    typedef struct packed {
        logic           prev;
        logic [DTW-1:0] run;
        logic           hi;
        logic           lo;
    } leg_state_t;

    leg_state_t lg_d, lg_q;
    logic raw;
    logic settled;
    logic side_a;
    logic side_b;
    logic sel_hi;
    logic sel_lo;

    // variant: direct or swapped output pair
    generate
        if (SWAP) begin : g_swap
            assign sel_hi = side_b;
            assign sel_lo = side_a;
        end else begin : g_direct
            assign sel_hi = side_a;
            assign sel_lo = side_b;
        end
    endgenerate

    always_comb begin
        raw  = ({1'b0, cnt} >= thr);
        lg_d = lg_q;
        if (!en) begin
            lg_d.prev = 1'b0;
            lg_d.run  = '0;
        end else begin
            lg_d.prev = raw;
            if (raw != lg_q.prev) begin
                lg_d.run = '0;
            end else if (lg_q.run != '1) begin
                lg_d.run = lg_q.run + DTW'(1);
            end
        end
        settled = (lg_d.run >= dt);
        side_a  = en && raw && settled;
        side_b  = en && !raw && settled;
        lg_d.hi = sel_hi;
        lg_d.lo = sel_lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q.prev <= 1'b0;
            lg_q.run  <= '0;
            lg_q.hi   <= 1'b0;
            lg_q.lo   <= 1'b0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign gate_hi = lg_q.hi;
    assign gate_lo = lg_q.lo;

endmodule

// File: rtl/fbpwm_bridge.sv
module fbpwm_bridge
    import fbpwm_pkg::*;
#(
    parameter int CW   = CW_DEF,
    parameter int DTW  = DTW_DEF,
    parameter int MINP = MINP_DEF
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           en_i,
    input  logic [CW-1:0]  prd_i,
    input  logic [CW-1:0]  duty_i,
    input  logic [DTW-1:0] dt_i,
    output logic           leg1_hi_o,
    output logic           leg1_lo_o,
    output logic           leg2_hi_o,
    output logic           leg2_lo_o,
    output logic [CW-1:0]  prd_link_o,
    output logic           resync_o
);

    localparam int NLEG = 2;

    logic [CW-1:0]  cnt_w;
    logic           load_w;
    logic [CW-1:0]  prd_act_w;
    logic [CW:0]    thr_act_w;
    logic [DTW-1:0] dt_act_w;
    logic           chg_w;
    logic [NLEG-1:0] hi_w;
    logic [NLEG-1:0] lo_w;

    fbpwm_timebase #(.CW(CW)) u_tb (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .en      (en_i),
        .prd_act (prd_act_w),
        .cnt     (cnt_w),
        .load    (load_w)
    );

    fbpwm_shadow #(.CW(CW), .DTW(DTW), .MINP(MINP)) u_shadow (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .en      (en_i),
        .load    (load_w),
        .prd_in  (prd_i),
        .duty_in (duty_i),
        .dt_in   (dt_i),
        .prd_act (prd_act_w),
        .thr_act (thr_act_w),
        .dt_act  (dt_act_w),
        .changed (chg_w)
    );

    fbpwm_resync u_resync (
        .clk     (clk_i),
        .rst_n   (rst_ni),
        .en      (en_i),
        .changed (chg_w),
        .pulse   (resync_o)
    );

    // leg index 1 swaps its pair to sit half a cycle away from leg 0
    generate
        for (genvar i = 0; i < NLEG; i++) begin : g_leg
            fbpwm_leg #(.CW(CW), .DTW(DTW), .SWAP(i == 1)) u_leg (
                .clk     (clk_i),
                .rst_n   (rst_ni),
                .en      (en_i),
                .cnt     (cnt_w),
                .thr     (thr_act_w),
                .dt      (dt_act_w),
                .gate_hi (hi_w[i]),
                .gate_lo (lo_w[i])
            );
        end
    endgenerate

    assign leg1_hi_o  = hi_w[0];
    assign leg1_lo_o  = lo_w[0];
    assign leg2_hi_o  = hi_w[1];
    assign leg2_lo_o  = lo_w[1];
    assign prd_link_o = prd_act_w;

endmodule

// File: rtl/fbpwm_bridge_chk.sv
module fbpwm_bridge_chk #(
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           g1h,
    input logic           g1l,
    input logic           g2h,
    input logic           g2l,
    input logic           sync,
    input logic [CW-1:0]  prd_act,
    input logic [CW-1:0]  cnt,
    input logic [DTW-1:0] dt_act
);

    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= prd_act);

    a_r3_leg1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(g1h && g1l));

    a_r3_leg2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(g2h && g2l));

    a_r3_gap_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_act != '0 && $rose(g1h)) |-> !$past(g1l));

    a_r4_legs_swapped: assert property (@(posedge clk) disable iff (!rst_n)
        (g2h == g1l) && (g2l == g1h));

    a_r7_hold_between_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != '0) |=> $stable(prd_act));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !sync);

    a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(g1h || g1l || g2h || g2l));

endmodule

bind fbpwm_bridge fbpwm_bridge_chk #(.CW(CW), .DTW(DTW)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .en      (en_i),
    .g1h     (leg1_hi_o),
    .g1l     (leg1_lo_o),
    .g2h     (leg2_hi_o),
    .g2l     (leg2_lo_o),
    .sync    (resync_o),
    .prd_act (prd_act_w),
    .cnt     (cnt_w),
    .dt_act  (dt_act_w)
);

// File: tb/fbpwm_bridge_tb.sv
module fbpwm_bridge_tb;

    localparam int CW  = 16;
    localparam int DTW = 8;

    logic           clk;
    logic           rst_n;
    logic           en;
    logic [CW-1:0]  prd;
    logic [CW-1:0]  duty;
    logic [DTW-1:0] dt;
    logic g1h, g1l, g2h, g2l, rs;
    logic [CW-1:0]  link;

    fbpwm_bridge #(.CW(CW), .DTW(DTW)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .prd_i      (prd),
        .duty_i     (duty),
        .dt_i       (dt),
        .leg1_hi_o  (g1h),
        .leg1_lo_o  (g1l),
        .leg2_hi_o  (g2h),
        .leg2_lo_o  (g2l),
        .prd_link_o (link),
        .resync_o   (rs)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        int    len;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   done   = 0;
    int   nsync  = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && rs) nsync++;

    // monitor: measures rise-to-rise windows of leg 1 high
    bit   prev_h = 1'b0;
    bit   meas   = 1'b0;
    exp_t cur;
    int   c_len, c_h, c_l, c_2h, c_2l;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_h = 1'b0;
            meas   = 1'b0;
        end else begin
            if (g1h && !prev_h) begin
                if (meas) begin
                    chk(c_len == cur.len, "R1", {cur.tag, " cycle length"}, c_len, cur.len);
                    chk(c_h == cur.hi, "R2", {cur.tag, " leg1 high width"}, c_h, cur.hi);
                    chk(c_l == cur.lo, "R3", {cur.tag, " leg1 low width"}, c_l, cur.lo);
                    chk(c_2h == cur.lo, "R4", {cur.tag, " leg2 high width"}, c_2h, cur.lo);
                    chk(c_2l == cur.hi, "R4", {cur.tag, " leg2 low width"}, c_2l, cur.hi);
                    meas = 1'b0;
                    done++;
                end
                if (q.size() > 0) begin
                    cur   = q.pop_front();
                    meas  = 1'b1;
                    c_len = 0; c_h = 0; c_l = 0; c_2h = 0; c_2l = 0;
                end
            end
            if (meas) begin
                c_len++;
                c_h  += int'(g1h);
                c_l  += int'(g1l);
                c_2h += int'(g2h);
                c_2l += int'(g2l);
            end
            prev_h = g1h;
        end
    end

    // driver: apply a setting, let it settle, push the expected cycle
    task automatic run_cfg(input int p, input int d, input int t, input string tag);
        int pe, de, lim;
        exp_t e;
        int target;
        @(negedge clk);
        prd  = CW'(p);
        duty = CW'(d);
        dt   = DTW'(t);
        repeat (250) @(negedge clk);
        pe   = (p < 2) ? 2 : p;
        lim  = (pe > t) ? pe - t : 0;
        de   = (d > lim) ? lim : d;
        e.len = 2 * pe;
        e.hi  = 2 * de - 1 - t;
        e.lo  = 2 * pe - 2 * de + 1 - t;
        e.tag = tag;
        target = done + 1;
        q.push_back(e);
        while (done < target) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        bit seen;
        rst_n = 1'b0;
        en    = 1'b0;
        prd   = CW'(20);
        duty  = CW'(8);
        dt    = DTW'(2);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!(g1h || g1l || g2h || g2l), "R10", "gates in reset", int'({g1h, g1l, g2h, g2l}), 0);
        chk(!rs, "R10", "resync in reset", int'(rs), 0);
        chk(link == CW'(2), "R10", "link period in reset", int'(link), 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 disabled: inputs load continuously
        chk(link == CW'(20), "R9", "link follows input while disabled", int'(link), 20);
        chk(nsync == 0, "R8", "no resync while disabled", nsync, 0);
        en = 1'b1;

        run_cfg(20, 8, 2, "R2 base");
        run_cfg(20, 8, 0, "R3 zero dead time");
        run_cfg(10, 3, 1, "R2 short period");
        run_cfg(12, 50, 3, "R5 duty clamp");
        run_cfg(1, 1, 0, "R6 period floor");

        // R5 zero duty: leg 1 high never on
        @(negedge clk);
        prd = CW'(16); duty = CW'(0); dt = DTW'(2);
        repeat (250) @(negedge clk);
        begin
            int nh = 0, nl = 0;
            for (int i = 0; i < 64; i++) begin
                nh += int'(g1h) + int'(g2l);
                nl += int'(g1l);
                @(negedge clk);
            end
            chk(nh == 0, "R5", "zero duty high count", nh, 0);
            chk(nl == 64, "R5", "zero duty low count", nl, 64);
        end

        // R7 / R8 shadow load and one-shot resync
        run_cfg(30, 10, 2, "R7 setup");
        while (g1h) @(negedge clk);
        while (!g1h) @(negedge clk);
        s0  = nsync;
        prd = CW'(24);
        @(negedge clk);
        chk(link == CW'(30), "R7", "period held before zero", int'(link), 30);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (rs) begin
                seen = 1'b1;
                chk(link == CW'(24), "R7", "period at resync", int'(link), 24);
            end else begin
                @(negedge clk);
            end
        end
        chk(seen, "R8", "resync after period change", int'(seen), 1);
        repeat (200) @(negedge clk);
        chk(nsync == s0 + 1, "R8", "single resync per change", nsync - s0, 1);
        dt = DTW'(4);
        repeat (200) @(negedge clk);
        chk(nsync == s0 + 1, "R8", "no resync for dead-time change", nsync - s0, 1);
        duty = CW'(9);
        repeat (200) @(negedge clk);
        chk(nsync == s0 + 2, "R8", "resync for duty change", nsync - s0, 2);

        // R9 disable
        en = 1'b0;
        @(negedge clk);
        chk(!(g1h || g1l || g2h || g2l), "R9", "gates off after disable", int'({g1h, g1l, g2h, g2l}), 0);
        s0  = nsync;
        prd = CW'(40);
        repeat (2) @(negedge clk);
        chk(link == CW'(40), "R9", "link follows input while disabled", int'(link), 40);
        chk(nsync == s0, "R8", "no resync while disabled", nsync - s0, 0);
        prd = CW'(24); duty = CW'(10); dt = DTW'(4);
        @(negedge clk);
        en = 1'b1;
        run_cfg(24, 10, 4, "R9 re-enable");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule